// File: doc/BRIEF.md
# Error Event Aggregator and Reporter

This block collects error events for a configurable number of functions and turns them into three one-cycle summary pulses: correctable, non-fatal and fatal. Each function keeps a small sticky status word. Core logic reports the errors it detects separately for each function. User logic can also inject a correctable or an uncorrectable internal error. Such an injected error belongs to no single function, so it is recorded in every enabled function at the same time.

Each function has its own mask bit for each error class. A masked class still records status, but it does not contribute to the summary pulses or to the message requests. A per-function message-enable bit decides whether a reportable event also raises a request to send an error message; the encoding of that message is handled elsewhere. In root-port mode, non-fatal and fatal detections that came from remote devices are dropped, so that only local errors are reported. Software clears status bits by writing ones through a function-select strobe.

Top module: `err_event_reporter`

## Requirements
- R1: After reset every status bit is 0 and all six pulse outputs are low.
- R2: A one-cycle `usr_cor_pulse` sets status bit 3 (corrected internal) in every function whose `fn_en` bit is 1. Disabled functions are left unchanged.
- R3: A one-cycle `usr_uncor_pulse` sets status bit 4 (uncorrected internal) in every enabled function. With the default `UNCOR_FATAL=1` it is reported in the fatal class; with `UNCOR_FATAL=0` it is reported in the non-fatal class.
- R4: A core detection on `det_cor`/`det_nf`/`det_fat` bit f sets status bit 0/1/2 of function f only, and only while that function is enabled.
- R5: `sum_cor`, `sum_nonfatal` and `sum_fatal` go high one cycle after an event of their class in any enabled, unmasked function. Each output is the OR across all functions.
- R6: A mask bit set in `cor_mask`, `nf_mask` or `fat_mask` for function f removes that function's events of that class from the summary and message outputs. The status bit is still set.
- R7: `msg_cor`, `msg_nonfatal` and `msg_fatal` go high one cycle after a reportable event of their class in a function whose `fn_msg_en` bit is 1.
- R8: Status bits are sticky. They clear only when `clr_fn[f]` and the matching `clr_bits` bit are 1 in the same cycle. A set and a clear of the same bit in the same cycle leave the bit at 1.
- R9: With `root_mode`=1 and `det_remote`=1, the non-fatal and fatal detections of that cycle are ignored: no status, no summary, no message. Correctable detections are still handled. With `root_mode`=0, `det_remote` has no effect.
- R10: A summary pulse lasts only one cycle for each event cycle. It does not repeat while the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_mode | input | 1 | 1 = root port, 0 = endpoint |
| usr_cor_pulse | input | 1 | User-injected correctable internal error |
| usr_uncor_pulse | input | 1 | User-injected uncorrectable internal error |
| fn_en | input | NUM_FUNC | Function enables |
| fn_msg_en | input | NUM_FUNC | Per-function message-sending enable |
| cor_mask | input | NUM_FUNC | Per-function correctable reporting mask |
| nf_mask | input | NUM_FUNC | Per-function non-fatal reporting mask |
| fat_mask | input | NUM_FUNC | Per-function fatal reporting mask |
| det_cor | input | NUM_FUNC | Core-detected correctable error for each function |
| det_nf | input | NUM_FUNC | Core-detected non-fatal error for each function |
| det_fat | input | NUM_FUNC | Core-detected fatal error for each function |
| det_remote | input | 1 | This cycle's non-fatal/fatal detections come from a remote device |
| clr_fn | input | NUM_FUNC | Function select for write-one-to-clear |
| clr_bits | input | 5 | Status bits to clear in the selected functions |
| sum_cor | output | 1 | Correctable summary pulse |
| sum_nonfatal | output | 1 | Non-fatal summary pulse |
| sum_fatal | output | 1 | Fatal summary pulse |
| msg_cor | output | 1 | Correctable message request |
| msg_nonfatal | output | 1 | Non-fatal message request |
| msg_fatal | output | 1 | Fatal message request |
| fn_status | output | NUM_FUNC*5 | Status of function f at bits [5f+4:5f] |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. This covers the status bits, the summary pulses and the message requests. The bench drives a stimulus at a falling edge, waits for the next falling edge and checks all outputs there. It then removes the stimulus and checks again one falling edge later, to confirm that the pulses have dropped while the sticky status bits stay set. Set-versus-clear collisions and remote-error filtering are checked in the same single-edge window.

// File: rtl/errag_pkg.sv
package errag_pkg;
   localparam int STS_W = 5;
   localparam int B_CE  = 0;
   localparam int B_NFE = 1;
   localparam int B_FE  = 2;
   localparam int B_CIE = 3;
   localparam int B_UIE = 4;
   localparam int CLS_W = 3;
   localparam int C_COR = 0;
   localparam int C_NF  = 1;
   localparam int C_FAT = 2;
endpackage

// File: rtl/errag_func.sv
module errag_func
   import errag_pkg::*;
#(
   parameter bit UNCOR_FATAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             msg_en,
   input  logic [CLS_W-1:0] mask,
   input  logic [CLS_W-1:0] det,
   input  logic             inj_cor,
   input  logic             inj_uncor,
   input  logic             clr_sel,
   input  logic [STS_W-1:0] clr_bits,
   output logic [STS_W-1:0] status,
   output logic [CLS_W-1:0] rpt,
   output logic [CLS_W-1:0] msg
);
   logic [STS_W-1:0] set_v;
   logic [STS_W-1:0] clr_v;
   logic [CLS_W-1:0] evt;

   always_comb begin
      set_v = '0;
      if (en) begin
         set_v[B_CE]  = det[C_COR];
         set_v[B_NFE] = det[C_NF];
         set_v[B_FE]  = det[C_FAT];
         set_v[B_CIE] = inj_cor;
         set_v[B_UIE] = inj_uncor;
      end
   end

   generate
      if (UNCOR_FATAL) begin : g_uie_fatal
         assign evt = {det[C_FAT] | inj_uncor, det[C_NF], det[C_COR] | inj_cor};
      end else begin : g_uie_nonfatal
         assign evt = {det[C_FAT], det[C_NF] | inj_uncor, det[C_COR] | inj_cor};
      end
   endgenerate

   assign rpt   = en ? (evt & ~mask) : '0;
   assign msg   = rpt & {CLS_W{msg_en}};
   assign clr_v = clr_sel ? clr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr_v) | set_v;
   end

   // R8: a set bit survives any cycle without a matching clear
   generate
      for (genvar b = 0; b < STS_W; b++) begin : g_sticky_chk
         a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            status[b] && !(clr_sel && clr_bits[b]) |=> status[b]);
      end
   endgenerate

   a_r2_inject_sets: assert property (@(posedge clk) disable iff (!rst_n)
      en && inj_cor |=> status[B_CIE]);

   a_r4_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en && !clr_sel |=> $stable(status));
endmodule

// File: rtl/errag_reduce.sv
module errag_reduce #(
   parameter int N = 4,
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] vec [N],
   output logic [W-1:0] any_q
);
   logic [W-1:0] any_d;

   always_comb begin
      any_d = '0;
      for (int i = 0; i < N; i++) any_d = any_d | vec[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) any_q <= '0;
      else        any_q <= any_d;
   end
endmodule

// File: rtl/err_event_reporter.sv
module err_event_reporter
   import errag_pkg::*;
#(
   parameter int NUM_FUNC    = 4,
   parameter bit UNCOR_FATAL = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      root_mode,
   input  logic                      usr_cor_pulse,
   input  logic                      usr_uncor_pulse,
   input  logic [NUM_FUNC-1:0]       fn_en,
   input  logic [NUM_FUNC-1:0]       fn_msg_en,
   input  logic [NUM_FUNC-1:0]       cor_mask,
   input  logic [NUM_FUNC-1:0]       nf_mask,
   input  logic [NUM_FUNC-1:0]       fat_mask,
   input  logic [NUM_FUNC-1:0]       det_cor,
   input  logic [NUM_FUNC-1:0]       det_nf,
   input  logic [NUM_FUNC-1:0]       det_fat,
   input  logic                      det_remote,
   input  logic [NUM_FUNC-1:0]       clr_fn,
   input  logic [STS_W-1:0]          clr_bits,
   output logic                      sum_cor,
   output logic                      sum_nonfatal,
   output logic                      sum_fatal,
   output logic                      msg_cor,
   output logic                      msg_nonfatal,
   output logic                      msg_fatal,
   output logic [NUM_FUNC*STS_W-1:0] fn_status
);
   localparam int MAX_FUNC = 256;

   generate
      if (NUM_FUNC < 1 || NUM_FUNC > MAX_FUNC) begin : g_bad_num_func
         $error("NUM_FUNC must be between 1 and %0d", MAX_FUNC);
      end
   endgenerate

   logic                 drop_remote;
   logic [NUM_FUNC-1:0]  nf_eff;
   logic [NUM_FUNC-1:0]  fat_eff;
   logic [CLS_W-1:0]     rpt_v [NUM_FUNC];
   logic [CLS_W-1:0]     msg_v [NUM_FUNC];
   logic [CLS_W-1:0]     sum_q;
   logic [CLS_W-1:0]     msg_q;

   assign drop_remote = root_mode & det_remote;
   assign nf_eff      = drop_remote ? '0 : det_nf;
   assign fat_eff     = drop_remote ? '0 : det_fat;

   generate
      for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
         errag_func #(.UNCOR_FATAL(UNCOR_FATAL)) i_func (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (fn_en[f]),
            .msg_en    (fn_msg_en[f]),
            .mask      ({fat_mask[f], nf_mask[f], cor_mask[f]}),
            .det       ({fat_eff[f], nf_eff[f], det_cor[f]}),
            .inj_cor   (usr_cor_pulse),
            .inj_uncor (usr_uncor_pulse),
            .clr_sel   (clr_fn[f]),
            .clr_bits  (clr_bits),
            .status    (fn_status[f*STS_W +: STS_W]),
            .rpt       (rpt_v[f]),
            .msg       (msg_v[f])
         );
      end
   endgenerate

   errag_reduce #(.N(NUM_FUNC), .W(CLS_W)) i_sum_or (
      .clk(clk), .rst_n(rst_n), .vec(rpt_v), .any_q(sum_q));

   errag_reduce #(.N(NUM_FUNC), .W(CLS_W)) i_msg_or (
      .clk(clk), .rst_n(rst_n), .vec(msg_v), .any_q(msg_q));

   assign sum_cor      = sum_q[C_COR];
   assign sum_nonfatal = sum_q[C_NF];
   assign sum_fatal    = sum_q[C_FAT];
   assign msg_cor      = msg_q[C_COR];
   assign msg_nonfatal = msg_q[C_NF];
   assign msg_fatal    = msg_q[C_FAT];

   a_r5_cor_summary: assert property (@(posedge clk) disable iff (!rst_n)
      usr_cor_pulse && |(fn_en & ~cor_mask) |=> sum_cor);

   a_r9_remote_drop: assert property (@(posedge clk) disable iff (!rst_n)
      root_mode && det_remote && !usr_uncor_pulse |=> !sum_fatal && !sum_nonfatal);

   a_r10_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      !usr_cor_pulse && (det_cor == '0) |=> !sum_cor);

   a_r7_msg_needs_summary: assert property (@(posedge clk) disable iff (!rst_n)
      msg_fatal |-> sum_fatal);
endmodule

// File: tb/test_err_event_reporter.sv
module test_err_event_reporter;
   localparam int NF = 4;
   localparam int SW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic root_mode = 1'b0, usr_cor = 1'b0, usr_uncor = 1'b0, det_remote = 1'b0;
   logic [NF-1:0] fn_en = '0, msg_en = '0, cor_mask = '0, nf_mask = '0, fat_mask = '0;
   logic [NF-1:0] det_cor = '0, det_nf = '0, det_fat = '0, clr_fn = '0;
   logic [SW-1:0] clr_bits = '0;
   logic sum_cor, sum_nf, sum_fat, m_cor, m_nf, m_fat;
   logic [NF*SW-1:0] fn_status;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   err_event_reporter #(.NUM_FUNC(NF)) i_err_event_reporter (
      .clk(clk), .rst_n(rst_n), .root_mode(root_mode),
      .usr_cor_pulse(usr_cor), .usr_uncor_pulse(usr_uncor),
      .fn_en(fn_en), .fn_msg_en(msg_en), .cor_mask(cor_mask), .nf_mask(nf_mask),
      .fat_mask(fat_mask), .det_cor(det_cor), .det_nf(det_nf), .det_fat(det_fat),
      .det_remote(det_remote), .clr_fn(clr_fn), .clr_bits(clr_bits),
      .sum_cor(sum_cor), .sum_nonfatal(sum_nf), .sum_fatal(sum_fat),
      .msg_cor(m_cor), .msg_nonfatal(m_nf), .msg_fatal(m_fat),
      .fn_status(fn_status));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] sts(input int f);
      return fn_status[f*SW +: SW];
   endfunction

   task automatic quiet();
      usr_cor = 0; usr_uncor = 0; det_cor = '0; det_nf = '0; det_fat = '0;
      det_remote = 0; clr_fn = '0; clr_bits = '0;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic clear_all();
      quiet(); clr_fn = '1; clr_bits = '1; step(); quiet(); step();
   endtask

   task automatic t_reset();
      chk("R1 status", fn_status, 0);
      chk("R1 pulses", {sum_cor, sum_nf, sum_fat, m_cor, m_nf, m_fat}, 0);
   endtask

   task automatic t_inject_cor();
      fn_en = 4'b1011; msg_en = 4'b0001;
      usr_cor = 1; step(); quiet();
      chk("R2 f0", sts(0), 5'h08); chk("R2 f1", sts(1), 5'h08);
      chk("R2 f2 disabled", sts(2), 5'h00); chk("R2 f3", sts(3), 5'h08);
      chk("R5 sum_cor", {sum_cor, sum_nf, sum_fat}, 3'b100);
      chk("R7 msg_cor", m_cor, 1);
      step();
      chk("R10 no repeat", {sum_cor, m_cor}, 0);
      chk("R8 held", sts(0), 5'h08);
   endtask

   task automatic t_inject_uncor();
      clear_all();
      fn_en = 4'b1111; msg_en = 4'b1111; fat_mask = 4'b1111;
      usr_uncor = 1; step(); quiet();
      chk("R3 f2 status", sts(2), 5'h10);
      chk("R6 masked fatal", {sum_fat, m_fat, sum_nf}, 0);
      fat_mask = 4'b1101;
      usr_uncor = 1; step(); quiet();
      chk("R3 fatal class", {sum_fat, sum_nf}, 2'b10);
      chk("R5 or across functions", m_fat, 1);
      step();
      chk("R10 fatal drops", sum_fat, 0);
      fat_mask = '0;
   endtask

   task automatic t_core_det();
      clear_all();
      fn_en = 4'b1111; msg_en = 4'b0000;
      det_nf = 4'b0100; step(); quiet();
      chk("R4 f2 nf", sts(2), 5'h02); chk("R4 f1 untouched", sts(1), 0);
      chk("R5 sum_nf", sum_nf, 1); chk("R7 msg off", m_nf, 0);
      fn_en = 4'b1110;
      det_cor = 4'b0001; step(); quiet();
      chk("R4 disabled f0", sts(0), 0); chk("R5 disabled no pulse", sum_cor, 0);
      fn_en = 4'b1111; msg_en = 4'b1000;
      det_fat = 4'b1000; step(); quiet();
      chk("R4 f3 fat", sts(3), 5'h04);
      chk("R7 msg_fatal", {sum_fat, m_fat}, 2'b11);
      cor_mask = 4'b0001; msg_en = 4'b0001;
      det_cor = 4'b0001; step(); quiet();
      chk("R6 cor masked status", sts(0), 5'h01);
      chk("R6 cor masked pulses", {sum_cor, m_cor}, 0);
      cor_mask = '0; msg_en = '0;
   endtask

   task automatic t_clear();
      clr_fn = 4'b0100; clr_bits = 5'h02; step(); quiet();
      chk("R8 cleared f2", sts(2), 0); chk("R8 f3 kept", sts(3), 5'h04);
      clr_fn = 4'b1000; clr_bits = 5'h04; det_fat = 4'b1000; step(); quiet();
      chk("R8 set wins", sts(3), 5'h04); chk("R5 collide pulse", sum_fat, 1);
      clr_fn = 4'b1000; clr_bits = 5'h1B; step(); quiet();
      chk("R8 other bits only", sts(3), 5'h04);
   endtask

   task automatic t_root();
      clear_all();
      fn_en = 4'b1111; msg_en = 4'b1111; root_mode = 1;
      det_remote = 1; det_fat = 4'b1111; det_nf = 4'b0011; det_cor = 4'b0001;
      step(); quiet();
      chk("R9 remote dropped f1", sts(1), 0); chk("R9 cor kept f0", sts(0), 5'h01);
      chk("R9 pulses", {sum_cor, sum_nf, sum_fat, m_nf, m_fat}, 5'b10000);
      det_fat = 4'b0010; step(); quiet();
      chk("R9 local fatal", {sts(1), 3'b000, sum_fat}, {5'h04, 3'b000, 1'b1});
      root_mode = 0;
      det_remote = 1; det_nf = 4'b0001; step(); quiet();
      chk("R9 endpoint ignores remote", sts(0), 5'h03);
      chk("R9 endpoint nf pulse", {sum_nf, m_nf}, 2'b11);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      quiet();
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_inject_cor();
      t_inject_uncor();
      t_core_det();
      t_clear();
      t_root();
      step();
      finish_run();
   end
endmodule